// File: doc/BRIEF.md
# Half-Word Output Splitter

This block connects the read side of a 36-bit show-ahead FIFO to an 18-bit output port. Every wide word reaches the narrow port as two halves, delivered on two successive narrow reads. The first of the two reads pops the word from the FIFO and keeps the half that is still owed. The second read returns that kept half and pops nothing.

The order of the two halves is fixed by the level on the order-select input while master reset is held. After reset that input is free for another use on the surrounding chip, and the splitter ignores it. A narrow read needs chip select low and read enable high, and there must be something to read. While chip select is high the output floats and the block's state does not change.

The narrow-side empty flag is raised only when the FIFO is empty and no second half is waiting. A consumer can therefore treat the FIFO and the splitter as one 18-bit queue.

Top module: `halfword_splitter`

## Requirements
- R1: A cycle with `rst_n` low at a rising edge clears the half-word state to the first half. The next narrow read after reset pops a fresh word, even if a second half was pending when reset arrived.
- R2: If `order_sel` is 1 at the last reset edge, each word is delivered upper half first (bits 35:18), then lower half (bits 17:0).
- R3: If `order_sel` is 0 at the last reset edge, each word is delivered lower half first (bits 17:0), then upper half (bits 35:18).
- R4: Changes on `order_sel` while `rst_n` is high have no effect on the half order.
- R5: `fifo_rd` is high in a cycle only when a narrow read takes the first half of a word. The FIFO is popped once for every two narrow reads and never in two cycles in a row.
- R6: While `cs_n` is 1, `dout` is high impedance, `fifo_rd` is 0 and no read takes place.
- R7: `empty_out` is 1 exactly when `fifo_empty` is 1 and no second half is pending. A read is never accepted while `empty_out` is 1.
- R8: The second half comes from the word captured at the pop, even if `fifo_rdata` changes afterwards.
- R9: With `rd_en` 0 no read takes place. `dout` keeps showing the same half and `fifo_rd` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Narrow-side clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous master reset, active low |
| order_sel | input | 1 | Half-order select, sampled only while reset is held (1 = upper half first) |
| fifo_rdata | input | 36 | Show-ahead data word at the head of the FIFO |
| fifo_empty | input | 1 | FIFO has no words |
| fifo_rd | output | 1 | Pops the head word of the FIFO at this rising edge |
| cs_n | input | 1 | Chip select, active low; high floats `dout` |
| rd_en | input | 1 | Narrow read enable, active high |
| dout | output | 18 | Narrow output half-word |
| empty_out | output | 1 | No half-word available on the narrow side |

## Verification
`dout`, `fifo_rd` and `empty_out` are combinational from the inputs and the half-word state. They must therefore be correct in the same cycle as the inputs that produce them. The half-word state and the captured half change at the rising edge after an accepted read, so their effect shows in the following cycle. The half order becomes valid at the first cycle after reset is released. The bench drives the inputs on the falling edge and compares all three outputs one time unit later. It updates its queue-based model just after the rising edge, so every comparison sees the settled result of exactly one edge.

// File: rtl/halfword_splitter.sv
module halfword_splitter #(
  parameter int WIDE_W = 36,
  localparam int HALF_W = WIDE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic [WIDE_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  input  logic              cs_n,
  input  logic              rd_en,
  output logic [HALF_W-1:0] dout,
  output logic              empty_out
);

  logic              hi_first;
  logic              second;
  logic              rd_take;
  logic [HALF_W-1:0] held;
  logic [HALF_W-1:0] first_half;

  assign empty_out  = fifo_empty & ~second;
  assign rd_take    = rst_n & ~cs_n & rd_en & ~empty_out;
  assign fifo_rd    = rd_take & ~second;
  assign first_half = hi_first ? fifo_rdata[WIDE_W-1:HALF_W] : fifo_rdata[HALF_W-1:0];
  assign dout       = cs_n ? {HALF_W{1'bz}} : (second ? held : first_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_first <= order_sel;
      second   <= 1'b0;
    end else if (rd_take) begin
      second <= ~second;
    end
  end

  always_ff @(posedge clk) begin
    if (fifo_rd)
      held <= hi_first ? fifo_rdata[HALF_W-1:0] : fifo_rdata[WIDE_W-1:HALF_W];
  end

  p_order_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(hi_first));

  p_pop_leaves_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !empty_out);

  p_no_back_to_back_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !fifo_rd);

  p_cs_blocks_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !fifo_rd);

  p_no_pop_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  p_empty_needs_fifo_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty_out |-> fifo_empty);

  p_idle_holds_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(second));

endmodule

// File: tb/sim_halfword_splitter.sv
module sim_halfword_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 36;
  localparam int HW = 18;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          order_sel = 1'b0;
  logic [WW-1:0] fifo_rdata = '0;
  logic          fifo_empty = 1'b1;
  logic          fifo_rd;
  logic          cs_n = 1'b1;
  logic          rd_en = 1'b0;
  logic [HW-1:0] dout;
  logic          empty_out;

  halfword_splitter #(.WIDE_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .cs_n(cs_n), .rd_en(rd_en), .dout(dout), .empty_out(empty_out)
  );

  logic [WW-1:0] q[$];
  bit            pend;
  logic [HW-1:0] pend_half;
  bit            big_ref;
  int            n_cmp = 0;
  int            n_bad = 0;
  int            seq = 1;
  string         tag = "R1";
  bit            done = 0;

  task automatic chk(string what, logic [HW-1:0] act, logic [HW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_rdata = (q.size() != 0) ? q[0] : '0;
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      logic [HW-1:0] s;
      s = HW'(seq * 37);
      q.push_back({~s, s});
      seq++;
    end
    refresh();
  endtask

  task automatic cyc(bit cs, bit en, bit osel);
    bit exp_empty, exp_take, exp_pop;
    logic [WW-1:0] w;
    cs_n = cs; rd_en = en; order_sel = osel;
    #1;
    exp_empty = (q.size() == 0) && !pend;
    exp_take  = !cs && en && !exp_empty;
    exp_pop   = exp_take && !pend;
    chk("empty_out", HW'(empty_out), HW'(exp_empty));
    chk("fifo_rd", HW'(fifo_rd), HW'(exp_pop));
    if (cs)
      chk("dout(float)", dout, {HW{1'bz}});
    else if (pend)
      chk("dout(second)", dout, pend_half);
    else if (q.size() != 0)
      chk("dout(first)", dout, big_ref ? q[0][WW-1:HW] : q[0][HW-1:0]);
    @(posedge clk); #1;
    if (exp_take) begin
      if (!pend) begin
        w = q.pop_front();
        pend_half = big_ref ? w[HW-1:0] : w[WW-1:HW];
        pend = 1;
      end else begin
        pend = 0;
      end
    end
    refresh();
    @(negedge clk);
  endtask

  task automatic do_reset(bit osel, int n);
    rst_n = 0; cs_n = 1; rd_en = 0; order_sel = osel;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    big_ref = osel;
    pend = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1, 3);
    tag = "R1"; cyc(0, 1, 1); cyc(1, 0, 0);
    push(3);
    tag = "R2"; repeat (7) cyc(0, 1, 1);
    push(3);
    tag = "R4";
    for (int i = 0; i < 7; i++) cyc(0, 1, i[0]);
    push(2);
    tag = "R6"; cyc(0, 1, 0); repeat (3) cyc(1, 1, 0); cyc(0, 1, 0); cyc(1, 1, 1);
    tag = "R9"; repeat (3) cyc(0, 0, 0); cyc(0, 1, 0); repeat (2) cyc(0, 0, 1); repeat (3) cyc(0, 1, 0);
    push(1);
    tag = "R7"; cyc(0, 1, 0); cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    push(1);
    tag = "R8"; cyc(0, 1, 0); push(1); cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    push(2);
    tag = "R1"; cyc(0, 1, 0);
    do_reset(1'b0, 2);
    cyc(0, 1, 1);
    tag = "R3"; repeat (4) cyc(0, 1, 1);
    push(8);
    tag = "R5";
    for (int i = 0; i < 24; i++) cyc(i % 5 == 3, i % 7 != 4, i[1]);
    repeat (4) cyc(0, 1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule